// File: doc/BRIEF.md
# Paged Serial Register Access Master

This block lets on-chip logic read and write byte-addressed registers of a device reached over a four-wire serial link (active-low select, clock, data out, data in). The device's register space is split into 256-register pages. A host presents one request at a time: a page number, a register offset, a length code, a direction and, for writes, up to four data bytes. The block turns the request into serial frames, waits for completion, and returns a one-cycle done pulse. A read also returns its data, and an error flag is raised when the device never acknowledges the read.

The block remembers the page it last selected on the device. A request to the same page goes straight to the register frame. A request to another page is preceded by a three-byte page-select frame. Reads use a fast-read command. The block then clocks out filler bytes and examines each returned byte until one has its least significant bit set. Only after that does it collect the data bytes. All serial timing (clock half-period, data setup, select setup) is set by parameters counted in system clock cycles.

Top module: `spi_page_master`

## Requirements
- R1: `spi_cs_n_o` is high at reset and between frames. Each frame holds it low for SS_SETUP_CYC cycles before the first clock edge. After the frame it is held high for SS_SETUP_CYC cycles. `spi_sck_o` is low whenever `spi_cs_n_o` is high.
- R2: Each byte is shifted most significant bit first. Multi-byte values travel least significant byte first: `req_wdata_i[7:0]` is sent first, and the first read data byte lands in `rsp_rdata_o[7:0]`.
- R3: `spi_mosi_o` changes only while `spi_sck_o` is low. Each low phase within a byte lasts at least max(HALF_CYC, MOSI_SETUP_CYC) cycles, and each high phase lasts exactly HALF_CYC cycles. `spi_miso_i` is sampled in the last cycle of the low phase.
- R4: A page-select frame has exactly three bytes: 0x61, 0xFF, then the new page number.
- R5: A write frame is 0x61, then the register offset, then the data bytes. The number of data bytes comes from `req_len_i`: code 0 gives 1 byte, code 1 gives 2 bytes, and codes 2 and 3 give 4 bytes.
- R6: A read frame starts with 0x10 and the register offset. The block then sends 0x00 bytes and polls each returned byte until one has bit 0 set. It then receives the requested number of data bytes. Unused upper bytes of `rsp_rdata_o` read as zero.
- R7: If MAX_POLL polled bytes in a row all have bit 0 clear, the read ends. It asserts `rsp_err_o` with `rsp_done_o`, returns zero data, and forgets the selected page, so the next access issues a page-select frame. An acknowledge in poll byte MAX_POLL itself still succeeds.
- R8: No page-select frame is sent when the requested page equals the last page selected since reset. The first access after reset always selects the page.
- R9: `req_ready_o` is high only while no request is in progress. A request is taken when `req_valid_i` and `req_ready_o` are both high. `rsp_done_o` is a one-cycle pulse, and `rsp_err_o` is high only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request accepted this cycle if valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_page_i | input | 8 | Register page |
| req_addr_i | input | 8 | Register offset within page |
| req_len_i | input | 2 | Length code (0: 1 byte, 1: 2 bytes, else 4 bytes) |
| req_wdata_i | input | 32 | Write data, little-endian byte order |
| rsp_done_o | output | 1 | Request finished (one cycle) |
| rsp_err_o | output | 1 | Read acknowledge timeout, valid with done |
| rsp_rdata_o | output | 32 | Read data, held until the next request |
| spi_cs_n_o | output | 1 | Active-low device select |
| spi_sck_o | output | 1 | Serial clock, idle low |
| spi_mosi_o | output | 1 | Serial data to device |
| spi_miso_i | input | 1 | Serial data from device |

## Verification
The bench drives writes of every length to a fresh page and then to the same page. This separates frame byte counts from one another, and a missed or spurious page-select frame shows up as a wrong frame count. Writes are followed by reads with acknowledge delays of zero, five, MAX_POLL-1 and MAX_POLL polled bytes. These distinguish an immediate acknowledge, a delayed one, the last allowed poll and a timeout. Data is checked in the device model's memory and again when it is read back, which catches a byte-order error that a read-after-write alone would hide. A read after the timeout shows that the page cache was invalidated.

// File: rtl/spi_page_pkg.sv
package spi_page_pkg;
  localparam logic [7:0] CMD_WRITE = 8'h61;
  localparam logic [7:0] CMD_FREAD = 8'h10;
  localparam logic [7:0] PAGE_REG  = 8'hFF;

  typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH} eng_state_e;
  typedef enum logic [1:0] {FR_PAGE, FR_WR, FR_RD} frame_e;
  typedef enum logic [1:0] {PH_HDR, PH_POLL, PH_DATA} phase_e;
  typedef enum logic [2:0] {S_IDLE, S_SEL, S_LOAD, S_WAIT, S_DESEL} seq_state_e;

  function automatic logic [2:0] len_bytes(input logic [1:0] code);
    case (code)
      2'd0:    len_bytes = 3'd1;
      2'd1:    len_bytes = 3'd2;
      default: len_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_page_pkg::*;
#(
  parameter int HALF_CYC       = 500,
  parameter int MOSI_SETUP_CYC = 250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic       busy_o,
  output logic [7:0] rx_o
);
  localparam int LOW_CYC = (HALF_CYC > MOSI_SETUP_CYC) ? HALF_CYC : MOSI_SETUP_CYC;
  localparam int CW      = $clog2(LOW_CYC + 1);

  eng_state_e      st_q;
  logic [CW-1:0]   cnt_q;
  logic [2:0]      bit_q;
  logic [7:0]      sh_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= E_IDLE;
      cnt_q  <= '0;
      bit_q  <= 3'd7;
      sh_q   <= '0;
      rx_q   <= '0;
      sck_o  <= 1'b0;
      mosi_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        E_IDLE: if (start_i) begin
          sh_q   <= tx_i;
          mosi_o <= tx_i[7];
          bit_q  <= 3'd7;
          cnt_q  <= '0;
          st_q   <= E_LOW;
        end
        E_LOW: begin
          if (cnt_q == CW'(LOW_CYC - 1)) begin
            rx_q  <= {rx_q[6:0], miso_i};
            sck_o <= 1'b1;
            cnt_q <= '0;
            st_q  <= E_HIGH;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        E_HIGH: begin
          if (cnt_q == CW'(HALF_CYC - 1)) begin
            cnt_q <= '0;
            sck_o <= 1'b0;
            if (bit_q == 3'd0) begin
              done_o <= 1'b1;
              st_q   <= E_IDLE;
            end else begin
              bit_q  <= bit_q - 3'd1;
              mosi_o <= sh_q[bit_q - 3'd1];
              st_q   <= E_LOW;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != E_IDLE);
  assign rx_o   = rx_q;

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o)); // R3
  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R3
endmodule

// File: rtl/spi_page_cache.sv
module spi_page_cache #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] query_i,
  input  logic          set_i,
  input  logic [PW-1:0] page_i,
  input  logic          inval_i,
  output logic          hit_o
);
  logic [PW-1:0] cur_q;
  logic          vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      vld_q <= 1'b0;
    end else if (inval_i) begin
      vld_q <= 1'b0;
    end else if (set_i) begin
      cur_q <= page_i;
      vld_q <= 1'b1;
    end
  end

  assign hit_o = vld_q && (cur_q == query_i);

  AST_NO_SET_AND_INVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && inval_i)); // R7
endmodule

// File: rtl/spi_page_master.sv
module spi_page_master
  import spi_page_pkg::*;
#(
  parameter int HALF_CYC       = 500,
  parameter int MOSI_SETUP_CYC = 250,
  parameter int SS_SETUP_CYC   = 250,
  parameter int MAX_POLL       = 100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [7:0]  req_page_i,
  input  logic [7:0]  req_addr_i,
  input  logic [1:0]  req_len_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_done_o,
  output logic        rsp_err_o,
  output logic [31:0] rsp_rdata_o,
  output logic        spi_cs_n_o,
  output logic        spi_sck_o,
  output logic        spi_mosi_o,
  input  logic        spi_miso_i
);
  localparam int SCW = $clog2(SS_SETUP_CYC + 1);
  localparam int PCW = $clog2(MAX_POLL + 1);

  seq_state_e     st_q;
  frame_e         kind_q, op_kind_q;
  phase_e         ph_q;
  logic [SCW-1:0] cnt_q;
  logic [2:0]     idx_q;
  logic [PCW-1:0] poll_q;
  logic [1:0]     dcnt_q;
  logic [2:0]     nbytes_q;
  logic [7:0]     page_q, addr_q;
  logic [31:0]    wd_q, rd_q;
  logic           more_q, err_q, done_q;

  logic       eng_start, eng_done, eng_busy;
  logic [7:0] eng_rx, tx_byte;
  logic       cache_hit, cache_set, cache_inval;

  spi_byte_shifter #(
    .HALF_CYC      (HALF_CYC),
    .MOSI_SETUP_CYC(MOSI_SETUP_CYC)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(eng_start),
    .tx_i   (tx_byte),
    .miso_i (spi_miso_i),
    .sck_o  (spi_sck_o),
    .mosi_o (spi_mosi_o),
    .done_o (eng_done),
    .busy_o (eng_busy),
    .rx_o   (eng_rx)
  );

  spi_page_cache #(.PW(8)) u_cache (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .query_i(req_page_i),
    .set_i  (cache_set),
    .page_i (page_q),
    .inval_i(cache_inval),
    .hit_o  (cache_hit)
  );

  assign eng_start = (st_q == S_LOAD);
  assign cache_set = (st_q == S_WAIT) && eng_done && (kind_q == FR_PAGE) && (idx_q == 3'd2);
  assign cache_inval = (st_q == S_WAIT) && eng_done && (kind_q == FR_RD) && (ph_q == PH_POLL)
                       && !eng_rx[0] && (poll_q == PCW'(MAX_POLL - 1));

  always_comb begin
    tx_byte = 8'h00;
    case (kind_q)
      FR_PAGE: case (idx_q)
        3'd0:    tx_byte = CMD_WRITE;
        3'd1:    tx_byte = PAGE_REG;
        default: tx_byte = page_q;
      endcase
      FR_WR: case (idx_q)
        3'd0:    tx_byte = CMD_WRITE;
        3'd1:    tx_byte = addr_q;
        3'd2:    tx_byte = wd_q[7:0];
        3'd3:    tx_byte = wd_q[15:8];
        3'd4:    tx_byte = wd_q[23:16];
        default: tx_byte = wd_q[31:24];
      endcase
      default: if (ph_q == PH_HDR) tx_byte = (idx_q == 3'd0) ? CMD_FREAD : addr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      kind_q     <= FR_PAGE;
      op_kind_q  <= FR_WR;
      ph_q       <= PH_HDR;
      cnt_q      <= '0;
      idx_q      <= '0;
      poll_q     <= '0;
      dcnt_q     <= '0;
      nbytes_q   <= 3'd1;
      page_q     <= '0;
      addr_q     <= '0;
      wd_q       <= '0;
      rd_q       <= '0;
      more_q     <= 1'b0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      spi_cs_n_o <= 1'b1;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid_i) begin
          page_q    <= req_page_i;
          addr_q    <= req_addr_i;
          wd_q      <= req_wdata_i;
          nbytes_q  <= len_bytes(req_len_i);
          op_kind_q <= req_write_i ? FR_WR : FR_RD;
          kind_q    <= cache_hit ? (req_write_i ? FR_WR : FR_RD) : FR_PAGE;
          more_q    <= !cache_hit;
          ph_q      <= PH_HDR;
          idx_q     <= '0;
          rd_q      <= '0;
          err_q     <= 1'b0;
          cnt_q     <= '0;
          spi_cs_n_o <= 1'b0;
          st_q      <= S_SEL;
        end
        S_SEL: begin
          if (cnt_q == SCW'(SS_SETUP_CYC - 1)) begin
            cnt_q <= '0;
            st_q  <= S_LOAD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_LOAD: st_q <= S_WAIT;
        S_WAIT: if (eng_done) begin
          st_q <= S_LOAD;
          case (kind_q)
            FR_PAGE: begin
              if (idx_q == 3'd2) begin
                spi_cs_n_o <= 1'b1;
                st_q       <= S_DESEL;
              end else idx_q <= idx_q + 3'd1;
            end
            FR_WR: begin
              if (idx_q == nbytes_q + 3'd1) begin
                more_q     <= 1'b0;
                spi_cs_n_o <= 1'b1;
                st_q       <= S_DESEL;
              end else idx_q <= idx_q + 3'd1;
            end
            default: begin
              case (ph_q)
                PH_HDR: begin
                  if (idx_q == 3'd1) begin
                    ph_q   <= PH_POLL;
                    poll_q <= '0;
                  end else idx_q <= idx_q + 3'd1;
                end
                PH_POLL: begin
                  if (eng_rx[0]) begin
                    ph_q   <= PH_DATA;
                    dcnt_q <= '0;
                  end else if (poll_q == PCW'(MAX_POLL - 1)) begin
                    err_q      <= 1'b1;
                    more_q     <= 1'b0;
                    spi_cs_n_o <= 1'b1;
                    st_q       <= S_DESEL;
                  end else poll_q <= poll_q + 1'b1;
                end
                default: begin
                  case (dcnt_q)
                    2'd0:    rd_q[7:0]   <= eng_rx;
                    2'd1:    rd_q[15:8]  <= eng_rx;
                    2'd2:    rd_q[23:16] <= eng_rx;
                    default: rd_q[31:24] <= eng_rx;
                  endcase
                  if ({1'b0, dcnt_q} == nbytes_q - 3'd1) begin
                    more_q     <= 1'b0;
                    spi_cs_n_o <= 1'b1;
                    st_q       <= S_DESEL;
                  end else dcnt_q <= dcnt_q + 2'd1;
                end
              endcase
            end
          endcase
        end
        S_DESEL: begin
          if (cnt_q == SCW'(SS_SETUP_CYC - 1)) begin
            cnt_q <= '0;
            if (more_q) begin
              more_q     <= 1'b0;
              kind_q     <= op_kind_q;
              idx_q      <= '0;
              ph_q       <= PH_HDR;
              spi_cs_n_o <= 1'b0;
              st_q       <= S_SEL;
            end else begin
              done_q <= 1'b1;
              st_q   <= S_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign rsp_done_o  = done_q;
  assign rsp_err_o   = done_q && err_q;
  assign rsp_rdata_o = rd_q;

  AST_SCK_LOW_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_n_o |-> !spi_sck_o); // R1
  AST_NOT_READY_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_cs_n_o |-> !req_ready_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o); // R9
  AST_POLL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_q < PCW'(MAX_POLL)); // R7
  AST_HIT_SKIPS_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i && cache_hit) |=> (kind_q != FR_PAGE)); // R8
  AST_ENGINE_IDLE_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_n_o |-> !eng_busy); // R1
endmodule

// File: tb/sim_spi_page_master.sv
module sim_spi_page_master;
  localparam int HALF = 2, MSU = 1, SSU = 2, MP = 100;
  localparam int LOWC = (HALF > MSU) ? HALF : MSU;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, write = 1'b0;
  logic [7:0] page = '0, addr = '0;
  logic [1:0] len = '0;
  logic [31:0] wdata = '0;
  logic ready, done, err, cs_n, sck, mosi, miso;
  logic [31:0] rdata;

  always #2 clk = ~clk;

  spi_page_master #(.HALF_CYC(HALF), .MOSI_SETUP_CYC(MSU), .SS_SETUP_CYC(SSU), .MAX_POLL(MP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready), .req_write_i(write),
    .req_page_i(page), .req_addr_i(addr), .req_len_i(len), .req_wdata_i(wdata),
    .rsp_done_o(done), .rsp_err_o(err), .rsp_rdata_o(rdata),
    .spi_cs_n_o(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_miso_i(miso));

  int n_chk = 0, n_fail = 0;

  // device model
  logic [7:0] mem [0:4095];
  logic [7:0] fb [0:255];
  logic [7:0] lfb [0:255];
  logic [7:0] shin = '0, tx = '0, spage = '0, pg_b0 = '0, pg_b1 = '0, pg_b2 = '0;
  logic [2:0] bitn = '0;
  int flen = 0, llen = 0, ack_delay = 0, n_frames = 0, n_pg = 0;

  assign miso = tx[~bitn];

  always @(posedge sck) if (!cs_n) begin
    shin = {shin[6:0], mosi};
    if (bitn == 3'd7) begin
      bitn = 0;
      fb[flen] = shin;
      flen++;
      if (fb[0] == 8'h10 && flen >= 2) begin
        int i;
        i = flen - 2;
        if (i < ack_delay) tx = 8'h00;
        else if (i == ack_delay) tx = 8'h01;
        else tx = mem[{spage[3:0], 8'(fb[1] + 8'(i - ack_delay - 1))}];
      end else tx = 8'h00;
    end else bitn++;
  end

  always @(posedge cs_n) begin
    if (flen > 0) begin
      n_frames++;
      if (fb[0] == 8'h61 && flen == 3 && fb[1] == 8'hFF) begin
        spage = fb[2]; n_pg++; pg_b0 = fb[0]; pg_b1 = fb[1]; pg_b2 = fb[2];
      end else if (fb[0] == 8'h61) begin
        for (int k = 2; k < flen; k++) mem[{spage[3:0], 8'(fb[1] + 8'(k - 2))}] = fb[k];
      end
      for (int k = 0; k < 256; k++) lfb[k] = fb[k];
      llen = flen;
    end
    flen = 0; bitn = 0; tx = 0;
  end

  // per-clock protocol monitor
  int v1 = 0, v3 = 0, v9 = 0, hi_run = 0, lo_run = 0;
  logic p_sck = 0, p_mosi = 0, p_done = 0;
  always @(negedge clk) if (rst_n) begin
    if (cs_n && sck) v1++;
    if (sck && p_sck && mosi !== p_mosi) v3++;
    if (sck) hi_run++;
    else if (p_sck) begin if (hi_run != HALF) v3++; hi_run = 0; end
    if (sck && !p_sck) begin if (lo_run < LOWC) v3++; lo_run = 0; end
    else if (!sck && !cs_n) lo_run++;
    if (cs_n) lo_run = 0;
    if (done && p_done) v9++;
    if (!cs_n && ready) v9++;
    if (err && !done) v9++;
    p_sck = sck; p_mosi = mosi; p_done = done;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xact(input logic w, input logic [7:0] pg, input logic [7:0] ad,
                      input logic [1:0] ln, input logic [31:0] wd,
                      output logic [31:0] rd, output logic er);
    @(negedge clk);
    valid = 1; write = w; page = pg; addr = ad; len = ln; wdata = wd;
    while (!ready) @(negedge clk);
    @(negedge clk);
    valid = 0;
    while (!done) @(negedge clk);
    rd = rdata; er = err;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic er;
    int f0, p0, nz;
    for (int k = 0; k < 4096; k++) mem[k] = 8'h00;
    mem[{4'h5, 8'h10}] = 8'h3C;
    repeat (3) @(negedge clk);
    chk("R1 reset cs_n", {31'd0, cs_n}, 32'd1);
    chk("R1 reset sck", {31'd0, sck}, 32'd0);
    chk("R9 reset ready", {31'd0, ready}, 32'd1);
    chk("R9 reset done", {31'd0, done}, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R8 first access selects page, R4 page frame bytes, R2/R5 4-byte write
    f0 = n_frames; p0 = n_pg;
    xact(1, 8'h03, 8'h20, 2'd2, 32'h12345678, rd, er);
    chk("R8 first access page frame", n_pg - p0, 1);
    chk("R8 frames first write", n_frames - f0, 2);
    chk("R4 page cmd", {24'd0, pg_b0}, 32'h61);
    chk("R4 page reg", {24'd0, pg_b1}, 32'hFF);
    chk("R4 page number", {24'd0, pg_b2}, 32'h03);
    chk("R5 len4 frame size", llen, 6);
    chk("R2 byte order mem", {mem[{4'h3, 8'h23}], mem[{4'h3, 8'h22}], mem[{4'h3, 8'h21}], mem[{4'h3, 8'h20}]}, 32'h12345678);

    // R8 same page, R5 1-byte write
    f0 = n_frames; p0 = n_pg;
    xact(1, 8'h03, 8'h30, 2'd0, 32'hFFFF_FFA5, rd, er);
    chk("R8 same page no select", n_pg - p0, 0);
    chk("R8 one frame", n_frames - f0, 1);
    chk("R5 len1 frame size", llen, 3);
    chk("R5 write cmd/offset/data", {8'd0, lfb[0], lfb[1], lfb[2]}, 32'h0061_30A5);
    chk("R5 neighbour untouched", {24'd0, mem[{4'h3, 8'h31}]}, 32'h00);

    // R5 2-byte write
    xact(1, 8'h03, 8'h40, 2'd1, 32'h0000BEEF, rd, er);
    chk("R5 len2 frame size", llen, 4);
    chk("R2 len2 mem", {16'd0, mem[{4'h3, 8'h41}], mem[{4'h3, 8'h40}]}, 32'h0000BEEF);

    // R6 read, immediate ack
    ack_delay = 0;
    xact(0, 8'h03, 8'h20, 2'd2, 32'h0, rd, er);
    chk("R6 read data len4", rd, 32'h12345678);
    chk("R6 no error", {31'd0, er}, 32'd0);
    chk("R6 read header", {16'd0, lfb[0], lfb[1]}, 32'h0000_1020);
    chk("R6 read frame size", llen, 7);

    // R6 delayed ack, 2 bytes, filler bytes zero
    ack_delay = 5;
    xact(0, 8'h03, 8'h40, 2'd1, 32'h0, rd, er);
    chk("R6 read data len2 delayed", rd, 32'h0000BEEF);
    chk("R6 delayed frame size", llen, 10);
    nz = 0;
    for (int k = 2; k < llen; k++) if (lfb[k] != 8'h00) nz++;
    chk("R6 filler bytes zero", nz, 0);

    // R7 boundary: ack in last allowed poll, new page R8
    ack_delay = MP - 1; p0 = n_pg;
    xact(0, 8'h05, 8'h10, 2'd0, 32'h0, rd, er);
    chk("R8 page change selects", n_pg - p0, 1);
    chk("R7 last poll ok data", rd, 32'h0000003C);
    chk("R7 last poll no error", {31'd0, er}, 32'd0);
    chk("R7 last poll frame size", llen, MP + 3);

    // R7 timeout
    ack_delay = MP;
    xact(0, 8'h05, 8'h10, 2'd0, 32'h0, rd, er);
    chk("R7 timeout error", {31'd0, er}, 32'd1);
    chk("R7 timeout data zero", rd, 32'h0);
    chk("R7 timeout frame size", llen, MP + 2);

    // R7 cache invalidated by timeout
    ack_delay = 0; p0 = n_pg;
    xact(0, 8'h05, 8'h10, 2'd0, 32'h0, rd, er);
    chk("R7 reselect after timeout", n_pg - p0, 1);
    chk("R7 read after timeout", rd, 32'h0000003C);

    repeat (4) @(negedge clk);
    chk("R1 sck low while deselected", v1, 0);
    chk("R3 sck phases and mosi timing", v3, 0);
    chk("R9 done pulse and ready", v9, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule